// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This unit settles conditional branches and direct jumps while the instruction sits in the decode stage of a five-stage in-order pipeline. A conditional branch tests one register for zero or non-zero with a reduction tree instead of the main ALU. A small dedicated adder forms the PC-relative target. A jump target is built by bit concatenation, so it needs no adder.

Fetch always proceeds sequentially, which is a static not-taken guess. When a branch is taken, or a jump is decoded, the unit redirects fetch to the target. It also raises a one-cycle flush that turns the wrong-path instruction already fetched into a NOP, so each redirect costs one cycle. If the tested register is still being produced by an older instruction (the hazard logic elsewhere reports this), the unit requests a stall. It then resolves again on a later cycle.

Top module: `id_branch_resolver`

## Requirements
- R1: While `rst_n` is low (sampled synchronously), `redirect`, `flush` and `stall` are 0 and `npc_sel` is 0, whatever the other inputs are.
- R2: `br_kind` encodings are 0 = no control transfer, 1 = branch if `src_val` equals zero, 2 = branch if `src_val` is non-zero, 3 = unconditional jump. A kind-1 branch is taken exactly when all 32 bits of `src_val` are 0. A kind-2 branch is taken exactly when at least one bit is 1.
- R3: For a taken conditional branch, `npc_target` = `pc_plus4` + (sign-extended `br_off` shifted left by 2), modulo 2^32, and `npc_sel` = 1.
- R4: For a jump, `npc_target` = {`pc_plus4`[31:28], `jmp_off`, 2'b00} and `npc_sel` = 2. A jump always redirects and flushes, whatever `src_val` and `src_pending` are.
- R5: A taken branch or jump raises `redirect` and `flush` in that same cycle, for exactly one cycle. A not-taken branch leaves `redirect` and `flush` at 0 and `npc_sel` at 0 (sequential).
- R6: A conditional branch with `src_pending` = 1 raises `stall`, and in that cycle raises neither `redirect` nor `flush`. The branch is resolved again from the inputs of the following cycle.
- R7: The cycle after a flush holds the squashed instruction. In that cycle `redirect`, `flush` and `stall` stay 0, whatever is on the inputs.
- R8: Kind 0 never raises `redirect`, `flush` or `stall`, even when `src_pending` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_plus4 | input | 32 | Address of the instruction after the one in decode |
| br_kind | input | 2 | Decoded control-transfer kind (see R2) |
| br_off | input | 16 | Signed word offset of a conditional branch |
| jmp_off | input | 26 | Word index field of a jump |
| src_val | input | 32 | Tested register value, already forwarded |
| src_pending | input | 1 | Tested register is not yet available |
| redirect | output | 1 | Fetch must load `npc_target` |
| npc_sel | output | 2 | Next-PC source: 0 sequential, 1 branch target, 2 jump target |
| npc_target | output | 32 | Target address (valid when `redirect` is 1) |
| flush | output | 1 | Replace the fetched instruction with a NOP |
| stall | output | 1 | Hold decode and fetch for one cycle |

## Verification
The zero test is driven with an all-zero operand, with each of the 32 one-hot operands and with a sign-bit-only value, under both conditional kinds. This separates a full reduction from one that misses a bit or swaps the sense. Branch offsets are positive, negative and large enough to wrap past the top of the address space, so faults in sign extension or the shift show up. Jumps carry an all-ones field under a set upper nibble, which exposes misplaced concatenation. Sequences of taken, squashed, pending-then-ready and back-to-back branches show whether the one-cycle flush, the squash slot and the stall priority are ordered correctly.

// File: rtl/id_br_pkg.sv
// Shared encodings for the decode-stage branch resolver.
// Assumes the decoder drives br_kind_e values and fetch decodes npc_sel_e.
package id_br_pkg;
    typedef enum logic [1:0] {
        BK_NONE = 2'd0,
        BK_EQZ  = 2'd1,
        BK_NEZ  = 2'd2,
        BK_JMP  = 2'd3
    } br_kind_e;

    typedef enum logic [1:0] {
        NS_SEQ = 2'd0,
        NS_BR  = 2'd1,
        NS_JMP = 2'd2
    } npc_sel_e;
endpackage

// File: rtl/id_zero_detect.sv
// Wide zero detector built as a two-level OR/NOR tree over 4-bit groups.
// Assumes W >= 1; upper padding bits of the last group are tied to zero.
module id_zero_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    output logic         is_zero_o
);
    localparam int GRP_W  = 4;
    localparam int GROUPS = (W + GRP_W - 1) / GRP_W;

    logic [GROUPS*GRP_W-1:0] padded;
    logic [GROUPS-1:0]       grp_any;

    // Place the operand into a group-aligned vector.
    always_comb begin
        padded        = '0;
        padded[W-1:0] = val_i;
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        // First level: any bit set inside this group.
        assign grp_any[g] = |padded[g*GRP_W +: GRP_W];
    end

    // Second level: NOR across all group results.
    assign is_zero_o = ~(|grp_any);
endmodule

// File: rtl/id_br_target.sv
// Dedicated PC-relative adder for conditional branch targets.
// Assumes word-addressed offsets: the offset is sign-extended and scaled by 4.
module id_br_target #(
    parameter int XLEN   = 32,
    parameter int BOFF_W = 16
) (
    input  logic [XLEN-1:0]   pc4_i,
    input  logic [BOFF_W-1:0] off_i,
    output logic [XLEN-1:0]   tgt_o
);
    localparam int SHIFT = 2;
    localparam int EXT_W = XLEN - BOFF_W - SHIFT;

    logic [XLEN-1:0] scaled;

    // Sign-extend and scale the word offset to a byte displacement.
    always_comb begin
        scaled = {{EXT_W{off_i[BOFF_W-1]}}, off_i, {SHIFT{1'b0}}};
        tgt_o  = pc4_i + scaled;
    end
endmodule

// File: rtl/id_jmp_target.sv
// Jump target former: keeps the region bits of PC+4 and inserts the word index.
// Assumes PC_HI + JOFF_W + 2 equals the address width.
module id_jmp_target #(
    parameter int PC_HI  = 4,
    parameter int JOFF_W = 26
) (
    input  logic [PC_HI-1:0]  pc_hi_i,
    input  logic [JOFF_W-1:0] off_i,
    output logic [PC_HI+JOFF_W+1:0] tgt_o
);
    // Pure concatenation, no carry chain.
    always_comb tgt_o = {pc_hi_i, off_i, 2'b00};
endmodule

// File: rtl/id_br_ctrl.sv
// Resolution control: decides redirect, flush and stall for the decode slot,
// and marks the slot after a flush as squashed so it is never acted upon.
// Assumes the zero flag and pending flag refer to the branch in decode.
module id_br_ctrl
    import id_br_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  br_kind_e kind_i,
    input  logic     is_zero_i,
    input  logic     pending_i,
    output logic     redirect_o,
    output logic     flush_o,
    output logic     stall_o,
    npc_sel_e        sel_o
);
    logic squash_q;
    logic live;
    logic is_cond;
    logic taken;

    // Remember that the next decode slot holds a squashed instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) squash_q <= 1'b0;
        else        squash_q <= flush_o;
    end

    // Resolve the decode slot: stall first, then redirect on a taken transfer.
    always_comb begin
        live    = rst_n && !squash_q;
        is_cond = (kind_i == BK_EQZ) || (kind_i == BK_NEZ);
        unique case (kind_i)
            BK_EQZ:  taken = is_zero_i;
            BK_NEZ:  taken = !is_zero_i;
            BK_JMP:  taken = 1'b1;
            default: taken = 1'b0;
        endcase
        stall_o    = live && is_cond && pending_i;
        redirect_o = live && taken && !stall_o;
        flush_o    = redirect_o;
        if (!redirect_o)           sel_o = NS_SEQ;
        else if (kind_i == BK_JMP) sel_o = NS_JMP;
        else                       sel_o = NS_BR;
    end

    // R5
    flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o);
    // R6
    stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (!redirect_o && !flush_o));
    // R4
    jump_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == BK_JMP && !squash_q) |-> (flush_o && sel_o == NS_JMP));
    // R8
    none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == BK_NONE) |-> (!redirect_o && !stall_o));
endmodule

// File: rtl/id_branch_resolver.sv
// Decode-stage branch resolver top: zero test, branch adder, jump former and
// control. Assumes src_val is already forwarded and src_pending comes from
// the hazard unit; fetch loads npc_target whenever redirect is high.
module id_branch_resolver
    import id_br_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int BOFF_W = 16,
    parameter int JOFF_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   pc_plus4,
    input  logic [1:0]        br_kind,
    input  logic [BOFF_W-1:0] br_off,
    input  logic [JOFF_W-1:0] jmp_off,
    input  logic [XLEN-1:0]   src_val,
    input  logic              src_pending,
    output logic              redirect,
    output logic [1:0]        npc_sel,
    output logic [XLEN-1:0]   npc_target,
    output logic              flush,
    output logic              stall
);
    localparam int PC_HI = XLEN - JOFF_W - 2;

    br_kind_e        kind;
    npc_sel_e        sel;
    logic            is_zero;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] jmp_tgt;

    // Interpret the decoded kind field.
    always_comb kind = br_kind_e'(br_kind);

    id_zero_detect #(.W(XLEN)) u_zero (
        .val_i     (src_val),
        .is_zero_o (is_zero)
    );

    id_br_target #(.XLEN(XLEN), .BOFF_W(BOFF_W)) u_badd (
        .pc4_i (pc_plus4),
        .off_i (br_off),
        .tgt_o (br_tgt)
    );

    id_jmp_target #(.PC_HI(PC_HI), .JOFF_W(JOFF_W)) u_jform (
        .pc_hi_i (pc_plus4[XLEN-1 -: PC_HI]),
        .off_i   (jmp_off),
        .tgt_o   (jmp_tgt)
    );

    id_br_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind_i     (kind),
        .is_zero_i  (is_zero),
        .pending_i  (src_pending),
        .redirect_o (redirect),
        .flush_o    (flush),
        .stall_o    (stall),
        .sel_o      (sel)
    );

    // Drive the next-PC select and pick the target matching the kind.
    always_comb begin
        npc_sel    = sel;
        npc_target = (kind == BK_JMP) ? jmp_tgt : br_tgt;
    end

    // R2
    eqz_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && kind == BK_EQZ) |-> (src_val == '0));
    // R2
    nez_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && kind == BK_NEZ) |-> (src_val != '0));
    // R3
    br_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (npc_sel == 2'd1) |-> (npc_target[1:0] == pc_plus4[1:0]));
    // R7
    squash_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!redirect && !stall && !flush));
endmodule

// File: tb/id_branch_resolver_tb.sv
`timescale 1ns/100ps
module id_branch_resolver_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_plus4 = '0;
    logic [1:0]  br_kind = '0;
    logic [15:0] br_off = '0;
    logic [25:0] jmp_off = '0;
    logic [31:0] src_val = '0;
    logic        src_pending = 1'b0;
    logic        redirect;
    logic [1:0]  npc_sel;
    logic [31:0] npc_target;
    logic        flush;
    logic        stall;

    int checks = 0;
    int failures = 0;
    bit m_squash = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    id_branch_resolver dut_i (
        .clk(clk), .rst_n(rst_n), .pc_plus4(pc_plus4), .br_kind(br_kind),
        .br_off(br_off), .jmp_off(jmp_off), .src_val(src_val),
        .src_pending(src_pending), .redirect(redirect), .npc_sel(npc_sel),
        .npc_target(npc_target), .flush(flush), .stall(stall)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // One decode cycle: drive after falling edge, compare to the model,
    // then advance the model's squash state at the rising edge.
    task automatic step(input string req, input logic rn, input logic [1:0] k,
                        input logic [31:0] pc4, input logic [15:0] bo,
                        input logic [25:0] jo, input logic [31:0] v,
                        input logic pend);
        bit act, tk, e_stall, e_red;
        int e_sel;
        logic [31:0] e_tgt;
        @(negedge clk);
        rst_n = rn; br_kind = k; pc_plus4 = pc4; br_off = bo;
        jmp_off = jo; src_val = v; src_pending = pend;
        #2;
        act = rn && !m_squash;
        tk = (k == 2'd3) || (k == 2'd1 && v == 0) || (k == 2'd2 && v != 0);
        e_stall = act && (k == 2'd1 || k == 2'd2) && pend;
        e_red = act && tk && !e_stall;
        e_sel = !e_red ? 0 : (k == 2'd3 ? 2 : 1);
        if (k == 2'd3) e_tgt = {pc4[31:28], jo, 2'b00};
        else           e_tgt = pc4 + 32'(int'($signed(bo)) * 4);
        chk(req, "redirect", 32'(redirect), 32'(e_red));
        chk(req, "flush", 32'(flush), 32'(e_red));
        chk(req, "stall", 32'(stall), 32'(e_stall));
        chk(req, "npc_sel", 32'(npc_sel), 32'(e_sel));
        if (e_red) chk(req, "npc_target", npc_target, e_tgt);
        @(posedge clk);
        m_squash = rn ? e_red : 1'b0;
    endtask

    initial begin
        // R1: reset suppresses a jump and a pending branch
        step("R1", 0, 2'd3, 32'h1000, 16'h0, 26'h1, 32'h0, 0);
        step("R1", 0, 2'd1, 32'h1000, 16'h2, 26'h0, 32'h0, 1);
        step("R1", 0, 2'd1, 32'h1000, 16'h2, 26'h0, 32'h0, 0);
        // R8: no control transfer
        step("R8", 1, 2'd0, 32'h1000, 16'h8, 26'h5, 32'h0, 0);
        step("R8", 1, 2'd0, 32'h1000, 16'h8, 26'h5, 32'h0, 1);
        // R2 R3 R5: equal-zero taken, positive offset
        step("R3", 1, 2'd1, 32'h1000, 16'h0008, 26'h0, 32'h0, 0);
        // R7: squashed slot ignores a jump
        step("R7", 1, 2'd3, 32'h1004, 16'h0, 26'h123, 32'h0, 0);
        // R2 R5: equal-zero not taken
        step("R5", 1, 2'd1, 32'h1008, 16'h0008, 26'h0, 32'h5, 0);
        // R2 R3: non-zero taken, negative offset, sign bit only
        step("R2", 1, 2'd2, 32'h2000, 16'hFFFC, 26'h0, 32'h80000000, 0);
        step("R7", 1, 2'd2, 32'h2004, 16'h0010, 26'h0, 32'h1, 1);
        // R2: non-zero not taken on zero
        step("R2", 1, 2'd2, 32'h2008, 16'h0010, 26'h0, 32'h0, 0);
        // R6: pending then ready
        step("R6", 1, 2'd1, 32'h3000, 16'h0004, 26'h0, 32'h0, 1);
        step("R6", 1, 2'd1, 32'h3000, 16'h0004, 26'h0, 32'h0, 1);
        step("R6", 1, 2'd1, 32'h3000, 16'h0004, 26'h0, 32'h0, 0);
        step("R7", 1, 2'd0, 32'h3004, 16'h0, 26'h0, 32'h0, 0);
        // R4 R6: jump ignores pending and operand
        step("R4", 1, 2'd3, 32'hA0000004, 16'h0, 26'h3FFFFFF, 32'h7, 1);
        step("R7", 1, 2'd1, 32'hA0000008, 16'h0, 26'h0, 32'h0, 0);
        step("R4", 1, 2'd3, 32'h50000000, 16'h0, 26'h0000001, 32'h0, 0);
        step("R7", 1, 2'd0, 32'h0, 16'h0, 26'h0, 32'h0, 0);
        // R3: wrap past the top of the address space
        step("R3", 1, 2'd1, 32'hFFFFFFF0, 16'h0010, 26'h0, 32'h0, 0);
        step("R7", 1, 2'd0, 32'h0, 16'h0, 26'h0, 32'h0, 0);
        step("R3", 1, 2'd2, 32'h00000010, 16'h8000, 26'h0, 32'hFFFFFFFF, 0);
        // R5 R7: back-to-back taken branches
        step("R5", 1, 2'd2, 32'h4000, 16'h0001, 26'h0, 32'h1, 0);
        step("R7", 1, 2'd2, 32'h4004, 16'h0001, 26'h0, 32'h1, 0);
        step("R5", 1, 2'd2, 32'h4008, 16'h0001, 26'h0, 32'h1, 0);
        step("R7", 1, 2'd0, 32'h0, 16'h0, 26'h0, 32'h0, 0);
        // R2: every one-hot operand under both conditional kinds
        for (int i = 0; i < 32; i++) begin
            step("R2", 1, 2'd1, 32'h5000, 16'h0002, 26'h0, 32'h1 << i, 0);
            step("R2", 1, 2'd2, 32'h5000, 16'h0002, 26'h0, 32'h1 << i, 0);
            step("R7", 1, 2'd0, 32'h0, 16'h0, 26'h0, 32'h0, 0);
        end
        // R1: reset in the squash slot clears it
        step("R5", 1, 2'd3, 32'h6000, 16'h0, 26'h10, 32'h0, 0);
        step("R1", 0, 2'd3, 32'h6004, 16'h0, 26'h10, 32'h0, 0);
        step("R4", 1, 2'd3, 32'h6008, 16'h0, 26'h20, 32'h0, 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule